// File: doc/BRIEF.md
# Parallel Printer Port Host Register File

This block is the host-facing register file of a PC-style parallel printer port. A byte-wide register bus reaches a status register at offset 1, a control register at offset 2, an enhanced-parallel-port (EPP) address register at offset 3 and four EPP data registers at offsets 4 to 7. The status register shows the printer's status inputs after synchronisation, together with a sticky acknowledge-pending flag. The control register drives the four handshake outputs, selects the data-bus direction and enables the acknowledge interrupt.

An external EPP transfer engine runs the byte handshakes; the engine is not part of this block. While that engine reports an active cycle, it takes over the strobe, data-strobe and address-strobe lines and sets the data-bus direction. The control register can still force those lines active. Writes to offsets 3 to 7 go to the engine as a one-cycle request carrying the offset and byte. Reads from those offsets return the byte the engine supplies.

Top module: `pport_regs`

## Requirements
- R1: After reset, with no EPP cycle active, `pin_stb_n`, `pin_afd_n`, `pin_init_n` and `pin_slin_n` are 1, `pd_drive` is 1, `irq` is 0 and status bit 2 reads 1.
- R2: Status byte layout is as follows. Bit 0 reads 0 and bit 1 reads 1. Bits 3, 4, 5 and 6 show the levels of `pin_err_n`, `pin_slct`, `pin_pe` and `pin_ack_n`, not inverted. Bit 7 reads 1 when `pin_busy` is 0. Each input is seen after a two-flop synchroniser, so it is valid from the third clock edge after it changes.
- R3: A rising edge on `pin_ack_n`, as seen after the synchroniser, makes status bit 2 read 0. The edge sets the flag whatever the interrupt enable is.
- R4: A read of offset 1 returns status bit 2 set to 1 from the next cycle. The exception is a synchronised `pin_ack_n` rising edge in the same cycle as the read: the flag then stays pending.
- R5: `irq` is 1 exactly when the pending flag is set and control bit 4 (interrupt enable) is 1.
- R6: Control bits 0, 1 and 3 are inverting: writing 1 drives `pin_stb_n`, `pin_afd_n` and `pin_slin_n` to 0. Control bit 2 is direct: `pin_init_n` equals the written bit. No EPP cycle changes `pin_init_n`.
- R7: A read of offset 2 returns the live pin levels, encoded with the write polarity: bit 0 = ~`pin_stb_n`, bit 1 = ~`pin_afd_n`, bit 2 = `pin_init_n`, bit 3 = ~`pin_slin_n`. Bits 4 and 5 return the stored values, and bits 7:6 read 0.
- R8: While `epp_active` is 1, `pin_stb_n`, `pin_afd_n` and `pin_slin_n` are 0 if either the EPP inputs `epp_write_n`, `epp_dstb_n` and `epp_astb_n` drive them to 0 or the control register forces them. While `epp_active` is 0, the EPP inputs have no effect.
- R9: `pd_drive` is 1 when control bit 5 is 0 and 0 when it is 1. While `epp_active` is 1, `pd_drive` instead equals `epp_is_write`.
- R10: A bus write to offset 3 to 7 produces, in the following cycle, `epp_req` = 1 for one cycle, with `epp_req_sel` equal to the offset and `epp_req_byte` equal to the written byte. Writes to other offsets produce no request.
- R11: A read of offset 3 to 7 returns `epp_rd_byte`, and a read of offset 0 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pin_err_n | input | 1 | Printer error input |
| pin_slct | input | 1 | Printer selected input |
| pin_pe | input | 1 | Paper-end input |
| pin_ack_n | input | 1 | Acknowledge input |
| pin_busy | input | 1 | Busy input |
| pin_stb_n | output | 1 | Strobe / EPP write line |
| pin_afd_n | output | 1 | Auto-feed / EPP data strobe line |
| pin_init_n | output | 1 | Initialise line |
| pin_slin_n | output | 1 | Select-in / EPP address strobe line |
| pd_drive | output | 1 | 1 = data pins driven by the host |
| irq | output | 1 | Acknowledge interrupt to the host |
| epp_active | input | 1 | EPP engine is in an address or data cycle |
| epp_is_write | input | 1 | Current EPP cycle is a host write |
| epp_write_n | input | 1 | EPP engine level for the strobe line |
| epp_dstb_n | input | 1 | EPP engine level for the auto-feed line |
| epp_astb_n | input | 1 | EPP engine level for the select-in line |
| epp_rd_byte | input | 8 | Byte returned for reads of offsets 3 to 7 |
| epp_req | output | 1 | One-cycle request after a write to offsets 3 to 7 |
| epp_req_sel | output | 3 | Offset of that write |
| epp_req_byte | output | 8 | Byte of that write |

## Verification
The assertions assume that every bus access lasts one cycle per request and uses an offset from 0 to 7. They also assume that the EPP inputs only matter while `epp_active` is 1, and that the printer inputs may change at any time because they pass through the synchroniser. The bench drives all inputs half a clock period away from the sampling edge. It holds every printer input for at least four cycles before it reads the status register. It places the one read that must coincide with an acknowledge edge in the single cycle where the synchronised edge is visible. Status reads happen only at known points, so the pending flag is never cleared by a read the expected-value model does not account for.

// File: rtl/pport_pkg.sv
// Package: shared offsets, widths and reset values of the parallel port
// register file. It assumes a byte-wide bus with eight register slots.
package pport_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int N_OVR    = 3;   // strobe lines the EPP engine can take over

    localparam logic [ADDR_W-1:0] OFS_NONE = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_STS  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_CTL  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_EPPA = 3'd3;

    // Stored control bits: [0] stb force, [1] afd force, [2] init level,
    // [3] slin force, [4] ack irq enable, [5] data input direction.
    localparam int CTL_W = 6;
    localparam logic [CTL_W-1:0] CTL_RST = 6'b00_0100;

    typedef struct packed {
        logic busy;
        logic ack_n;
        logic pe;
        logic slct;
        logic err_n;
    } pp_status_t;
endpackage

// File: rtl/pport_sync.sv
// Module: multi-flop synchroniser for a vector of asynchronous inputs.
// It assumes each bit is independent. No bus coherence is implied.
module pport_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rst_val,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift each input through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= rst_val;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pport_ack_irq.sv
// Module: acknowledge edge detector and sticky pending flag.
// It assumes ack_s is already synchronised. A rising edge and a status
// read in the same cycle leave the flag set.
module pport_ack_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_s,
    input  logic sts_rd,
    input  logic irq_en,
    output logic ack_rise,
    output logic pend,
    output logic irq
);
    logic ack_d;

    // Delay the synchronised level by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_d <= 1'b1;
        else        ack_d <= ack_s;
    end

    assign ack_rise = ack_s & ~ack_d;

    // Set the flag on an edge; a status read clears it, and the edge wins.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend <= 1'b0;
        else if (ack_rise) pend <= 1'b1;
        else if (sts_rd)   pend <= 1'b0;
    end

    assign irq = pend & irq_en;
endmodule

// File: rtl/pport_pin_mux.sv
// Module: merges the control register with the EPP engine for the output
// lines and the data direction. Active-low lines are ANDed, so either
// source can pull a line active. INIT is never taken over.
module pport_pin_mux
    import pport_pkg::*;
(
    input  logic [CTL_W-1:0] ctl,
    input  logic             epp_active,
    input  logic             epp_is_write,
    input  logic [N_OVR-1:0] epp_lines_n,   // {astb, dstb, write}
    output logic [N_OVR-1:0] ovr_pins_n,    // {slin, afd, stb}
    output logic             init_n,
    output logic             pd_drive
);
    logic [N_OVR-1:0] force_bits;
    assign force_bits = {ctl[3], ctl[1], ctl[0]};

    // Each overridable line is low if the register forces it or EPP drives it.
    for (genvar g = 0; g < N_OVR; g++) begin : g_line
        assign ovr_pins_n[g] = ~force_bits[g] & (~epp_active | epp_lines_n[g]);
    end

    assign init_n   = ctl[2];
    assign pd_drive = epp_active ? epp_is_write : ~ctl[5];
endmodule

// File: rtl/pport_regs.sv
// Module: top of the parallel port register file. It decodes the byte bus,
// holds the control register, forwards EPP writes as a one-cycle request,
// and builds the status and control read-back bytes from live pin levels.
// It assumes single-cycle bus accesses with combinational read data.
module pport_regs
    import pport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              pin_err_n,
    input  logic              pin_slct,
    input  logic              pin_pe,
    input  logic              pin_ack_n,
    input  logic              pin_busy,
    output logic              pin_stb_n,
    output logic              pin_afd_n,
    output logic              pin_init_n,
    output logic              pin_slin_n,
    output logic              pd_drive,
    output logic              irq,
    input  logic              epp_active,
    input  logic              epp_is_write,
    input  logic              epp_write_n,
    input  logic              epp_dstb_n,
    input  logic              epp_astb_n,
    input  logic [BYTE_W-1:0] epp_rd_byte,
    output logic              epp_req,
    output logic [ADDR_W-1:0] epp_req_sel,
    output logic [BYTE_W-1:0] epp_req_byte
);
    localparam int STS_W = $bits(pp_status_t);

    pp_status_t       sts_raw, sts_s;
    logic [CTL_W-1:0] ctl_q;
    logic             wr_en, rd_en, sts_rd, ack_rise, pend;
    logic [N_OVR-1:0] ovr_n;

    assign wr_en  = bus_sel & bus_wr;
    assign rd_en  = bus_sel & ~bus_wr;
    assign sts_rd = rd_en & (bus_addr == OFS_STS);

    assign sts_raw = '{busy: pin_busy, ack_n: pin_ack_n, pe: pin_pe,
                       slct: pin_slct, err_n: pin_err_n};

    pport_sync #(.WIDTH(STS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val (STS_W'(5'b01001)),
        .d       (sts_raw),
        .q       (sts_s)
    );

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ctl_q <= CTL_RST;
        else if (wr_en && bus_addr == OFS_CTL)   ctl_q <= bus_wdata[CTL_W-1:0];
    end

    // Forward writes to offsets 3..7 to the EPP engine as a one-cycle request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epp_req      <= 1'b0;
            epp_req_sel  <= OFS_NONE;
            epp_req_byte <= '0;
        end else begin
            epp_req <= wr_en && (bus_addr >= OFS_EPPA);
            if (wr_en && bus_addr >= OFS_EPPA) begin
                epp_req_sel  <= bus_addr;
                epp_req_byte <= bus_wdata;
            end
        end
    end

    pport_ack_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_s    (sts_s.ack_n),
        .sts_rd   (sts_rd),
        .irq_en   (ctl_q[4]),
        .ack_rise (ack_rise),
        .pend     (pend),
        .irq      (irq)
    );

    pport_pin_mux u_mux (
        .ctl          (ctl_q),
        .epp_active   (epp_active),
        .epp_is_write (epp_is_write),
        .epp_lines_n  ({epp_astb_n, epp_dstb_n, epp_write_n}),
        .ovr_pins_n   (ovr_n),
        .init_n       (pin_init_n),
        .pd_drive     (pd_drive)
    );

    assign pin_stb_n  = ovr_n[0];
    assign pin_afd_n  = ovr_n[1];
    assign pin_slin_n = ovr_n[2];

    // Read-data mux: status, control read-back from live pins, EPP bytes.
    always_comb begin
        unique case (bus_addr)
            3'd0: bus_rdata = '0;
            OFS_STS: bus_rdata = {~sts_s.busy, sts_s.ack_n, sts_s.pe, sts_s.slct,
                                  sts_s.err_n, ~pend, 1'b1, 1'b0};
            OFS_CTL: bus_rdata = {2'b00, ctl_q[5], ctl_q[4], ~pin_slin_n,
                                  pin_init_n, ~pin_afd_n, ~pin_stb_n};
            default: bus_rdata = epp_rd_byte;
        endcase
    end
endmodule

// File: rtl/pport_regs_chk.sv
// Checker for pport_regs, bound to every instance. It assumes one access
// per cycle and observes the pending flag and edge strobe inside the top.
module pport_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [2:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       pin_stb_n,
    input logic       pin_init_n,
    input logic       pd_drive,
    input logic       irq,
    input logic       epp_active,
    input logic       epp_is_write,
    input logic       epp_req,
    input logic       ack_rise,
    input logic       pend
);
    logic rd_sts, rd_ctl, wr_ctl, wr_any;
    assign rd_sts = bus_sel && !bus_wr && bus_addr == 3'd1;
    assign rd_ctl = bus_sel && !bus_wr && bus_addr == 3'd2;
    assign wr_ctl = bus_sel && bus_wr && bus_addr == 3'd2;
    assign wr_any = bus_sel && bus_wr;

    AST_STS_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sts |-> (bus_rdata[1:0] == 2'b10));                          // R2
    AST_ACK_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rise |=> pend);                                             // R3
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sts && !ack_rise) |=> !pend);                               // R4
    AST_IRQ_SHOWS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sts && irq) |-> !bus_rdata[2]);                             // R5
    AST_INIT_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> (pin_init_n == $past(bus_wdata[2])));                // R6
    AST_CTL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctl |-> (bus_rdata[7:6] == 2'b00));                          // R7
    AST_STB_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !bus_wdata[0]) |=> (epp_active || pin_stb_n));       // R8
    AST_DIR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && bus_wdata[5]) |=>
            (epp_active ? (pd_drive == epp_is_write) : !pd_drive));     // R9
    AST_REQ_ONLY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        epp_req |-> $past(wr_any && bus_addr >= 3'd3));                 // R10
endmodule

bind pport_regs pport_regs_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .pin_stb_n    (pin_stb_n),
    .pin_init_n   (pin_init_n),
    .pd_drive     (pd_drive),
    .irq          (irq),
    .epp_active   (epp_active),
    .epp_is_write (epp_is_write),
    .epp_req      (epp_req),
    .ack_rise     (ack_rise),
    .pend         (pend)
);

// File: tb/pport_regs_tb.sv
// Bench: sweeps status inputs, all control bytes against all EPP line
// combinations, the acknowledge interrupt sequences and EPP forwarding.
module pport_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 0, bus_wr = 0;
    logic [2:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic       pin_err_n = 1, pin_slct = 0, pin_pe = 0, pin_ack_n = 1, pin_busy = 0;
    logic       pin_stb_n, pin_afd_n, pin_init_n, pin_slin_n, pd_drive, irq;
    logic       epp_active = 0, epp_is_write = 0;
    logic       epp_write_n = 1, epp_dstb_n = 1, epp_astb_n = 1;
    logic [7:0] epp_rd_byte = 8'h00;
    logic       epp_req;
    logic [2:0] epp_req_sel;
    logic [7:0] epp_req_byte;
    int         errors = 0, checks = 0;
    logic [7:0] rd;

    always #10 clk = ~clk;   // 50 MHz

    pport_regs u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 stb", pin_stb_n, 1); chk("R1 afd", pin_afd_n, 1);
        chk("R1 init", pin_init_n, 1); chk("R1 slin", pin_slin_n, 1);
        chk("R1 drive", pd_drive, 1); chk("R1 irq", irq, 0);
        bus_read(3'd1, rd); chk("R1 pend", rd[2], 1);

        // R2 sweep all status input levels (ACK held high so no edges)
        for (int v = 0; v < 16; v++) begin
            {pin_busy, pin_pe, pin_slct, pin_err_n} = v[3:0];
            settle();
            bus_read(3'd1, rd);
            chk("R2 status", rd, {~v[3], 1'b1, v[2], v[1], v[0], 1'b1, 2'b10});
        end
        // R3 ACK low then rising edge sets pending, enable off
        pin_ack_n = 0; settle();
        bus_read(3'd1, rd); chk("R2 ack level", rd[6], 0);
        chk("R3 no pend on fall", rd[2], 1);
        pin_ack_n = 1; settle();
        chk("R5 irq off when disabled", irq, 0);
        bus_read(3'd1, rd); chk("R3 pend set", rd[2], 0);
        // R4 cleared by that read
        bus_read(3'd1, rd); chk("R4 cleared", rd[2], 1);
        // R5 enable with pending
        bus_write(3'd2, 8'h14);
        pin_ack_n = 0; settle(); pin_ack_n = 1; settle();
        chk("R5 irq on", irq, 1);
        bus_read(3'd1, rd); chk("R5 pend seen", rd[2], 0);
        @(negedge clk); chk("R5 irq off after read", irq, 0);
        // R4 read coinciding with the synchronised edge keeps pending
        pin_ack_n = 0; settle();
        @(negedge clk); pin_ack_n = 1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = 3'd1;
        @(negedge clk); bus_sel = 0;
        chk("R4 edge wins", irq, 1);
        bus_read(3'd1, rd); chk("R4 still pend", rd[2], 0);
        @(negedge clk); chk("R4 then clear", irq, 0);

        // R6-R9 sweep every control byte over every EPP combination
        for (int v = 0; v < 256; v++) begin
            bus_write(3'd2, v[7:0]);
            for (int e = 0; e < 32; e++) begin
                logic es, ed, ea, ew, ei, stb_e, afd_e, slin_e, drv_e;
                @(negedge clk);
                {ei, ea, es, ed, ew} = e[4:0];
                {epp_is_write, epp_active, epp_astb_n, epp_dstb_n, epp_write_n} = e[4:0];
                bus_sel = 1; bus_wr = 0; bus_addr = 3'd2;
                #2;
                stb_e  = !(v[0] || (ea && !ew));
                afd_e  = !(v[1] || (ea && !ed));
                slin_e = !(v[3] || (ea && !es));
                drv_e  = ea ? ei : !v[5];
                chk(ea ? "R8 stb" : "R6 stb", pin_stb_n, stb_e);
                chk(ea ? "R8 afd" : "R6 afd", pin_afd_n, afd_e);
                chk(ea ? "R8 slin" : "R6 slin", pin_slin_n, slin_e);
                chk("R6 init", pin_init_n, v[2]);
                chk("R9 drive", pd_drive, drv_e);
                chk("R7 readback", bus_rdata,
                    {2'b00, v[5], v[4], !slin_e, v[2], !afd_e, !stb_e});
                bus_sel = 0;
            end
        end
        @(negedge clk); epp_active = 0;

        // R10 EPP write forwarding, R11 EPP reads
        for (int a = 0; a < 8; a++) begin
            @(negedge clk);
            bus_sel = 1; bus_wr = 1; bus_addr = a[2:0]; bus_wdata = 8'h5A ^ a[7:0];
            @(negedge clk); bus_sel = 0;
            chk("R10 req", epp_req, a >= 3);
            if (a >= 3) begin
                chk("R10 sel", epp_req_sel, a);
                chk("R10 byte", epp_req_byte, 8'h5A ^ a[7:0]);
            end
            @(negedge clk); chk("R10 single", epp_req, 0);
            epp_rd_byte = 8'hC3 ^ a[7:0];
            if (a != 1 && a != 2) begin
                bus_read(a[2:0], rd);
                chk("R11 read", rd, (a == 0) ? 8'h00 : (8'hC3 ^ a[7:0]));
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule